// File: doc/BRIEF.md
# Single-Beat AXI4-Lite Master with Response Timeout

This block turns one command at a time into a single AXI4-Lite transfer. A command carries an address, write data, a transfer size and a read/write flag, and arrives on a valid/ready request channel. The block drives the matching address and data channels of the bus. It waits for the slave's answer and then offers a response record on a valid/ready reply channel. The record holds a 3-bit result code and, for reads, the returned data.

A programmable cycle limit guards every transfer. If the slave has not answered within that many cycles, the block withdraws whatever it is still presenting on the bus and reports a timeout code. A separate state output gives the result of the most recent transfer. A debug controller or boot loader can poll it to see whether a transfer is in flight and how the last one ended.

Top module: `axil_single_master`

## Requirements
- R1: After reset the state output reads 0 (idle), the request channel is ready, and no bus valid or reply valid is asserted.
- R2: One cycle after a command is accepted, the state output reads 1 (running). The request ready stays low from then until the reply handshake completes.
- R3: A write raises the address valid and the write-data valid together in the cycle after acceptance. Each one stays high until its own handshake and then drops. The address and data presented are those of the command.
- R4: The write strobe depends on the size code n (a transfer of 2^n bytes) and the low address bits. It enables byte lanes base to base+2^n-1, where base is the lane offset rounded down to a multiple of 2^n. A size of the full bus width or larger enables every lane.
- R5: A read raises the read-address valid in the cycle after acceptance and holds it until its handshake. It presents the command address, and the read-response ready is high from the first running cycle.
- R6: A slave response code of 00, 01, 10 or 11 gives result 3, 4, 5 or 6. The reply valid rises in the cycle after the response handshake. The state output keeps that result after the reply has been taken.
- R7: A read reply carries the data returned by the slave. A write reply or a timed-out reply carries zero data.
- R8: With limit L, if no response has been accepted by the L-th running cycle (counting from 0), the reply valid rises L+1 cycles after acceptance with result 2. All bus valids are low by then.
- R9: The reply valid and its code and data hold steady until reply ready is seen. The following cycle the request channel is ready again.
- R10: Each transfer is a single beat: exactly one address and one write-data handshake for a write, or exactly one read-address handshake for a read. Read and write channels are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmo_limit | input | TMO_W | Running-cycle index at which an unanswered transfer is abandoned |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Transfer address |
| cmd_wdata | input | DATA_W | Write data |
| cmd_size | input | 3 | Size code, 2^n bytes |
| rsp_valid | output | 1 | Reply record offered |
| rsp_ready | input | 1 | Reply record taken |
| rsp_status | output | 3 | Result code of the reply |
| rsp_rdata | output | DATA_W | Read data of the reply |
| txn_state | output | 3 | Idle, running or last result, for polling |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | ADDR_W | Write address |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write byte strobes |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response code |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | ADDR_W | Read address |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response code |

## Verification
The running state and the bus valids are due in the first cycle after the accepting edge. The bench samples them at the falling edge that follows that edge. The slave model records the clock count of the edge on which it will complete the response handshake. The bench then requires the reply to be visible at the falling edge carrying exactly that count, which tests the one-register delay of R6. For timeouts, the reply must appear at the falling edge whose count equals the accepting edge plus L+1, and must be absent at every earlier one. Strobes are swept over all eight size codes and all eight lane offsets, and the expected masks are computed arithmetically.

// File: rtl/axil_sm_pkg.sv
package axil_sm_pkg;

    typedef enum logic [2:0] {
        TXN_IDLE    = 3'd0,
        TXN_BUSY    = 3'd1,
        TXN_TIMEOUT = 3'd2,
        TXN_OKAY    = 3'd3,
        TXN_EXOKAY  = 3'd4,
        TXN_SLVERR  = 3'd5,
        TXN_DECERR  = 3'd6
    } txn_status_e;

    typedef enum logic [1:0] {
        FSM_IDLE  = 2'd0,
        FSM_WRITE = 2'd1,
        FSM_READ  = 2'd2,
        FSM_REPLY = 2'd3
    } fsm_e;

endpackage

// File: rtl/axil_sm_strobe.sv
module axil_sm_strobe #(
    parameter int STRB_W = 8,
    parameter int LANE_W = 3
) (
    input  logic [2:0]        size,
    input  logic [LANE_W-1:0] lane,
    output logic [STRB_W-1:0] strb
);

    // A lane is enabled when it shares every address bit above the size
    // with the requested offset.
    for (genvar i = 0; i < STRB_W; i++) begin : g_lane
        localparam logic [LANE_W-1:0] IDX = LANE_W'(i);
        assign strb[i] = (((IDX ^ lane) >> size) == '0);
    end

endmodule

// File: rtl/axil_sm_timer.sv
module axil_sm_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run && (cnt_q != '1)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = run && (cnt_q == limit);

endmodule

// File: rtl/axil_sm_resp_map.sv
module axil_sm_resp_map
    import axil_sm_pkg::*;
(
    input  logic [1:0]  resp,
    output txn_status_e code
);

    always_comb begin
        unique case (resp)
            2'b00:   code = TXN_OKAY;
            2'b01:   code = TXN_EXOKAY;
            2'b10:   code = TXN_SLVERR;
            default: code = TXN_DECERR;
        endcase
    end

endmodule

// File: rtl/axil_single_master.sv
module axil_single_master
    import axil_sm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [2:0]        cmd_size,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [2:0]        rsp_status,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [2:0]        txn_state,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [ADDR_W-1:0] m_awaddr,
    output logic              m_wvalid,
    input  logic              m_wready,
    output logic [DATA_W-1:0] m_wdata,
    output logic [DATA_W/8-1:0] m_wstrb,
    input  logic              m_bvalid,
    output logic              m_bready,
    input  logic [1:0]        m_bresp,
    output logic              m_arvalid,
    input  logic              m_arready,
    output logic [ADDR_W-1:0] m_araddr,
    input  logic              m_rvalid,
    output logic              m_rready,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic [1:0]        m_rresp
);

    localparam int STRB_W = DATA_W / 8;
    localparam int LANE_W = $clog2(STRB_W);

    typedef struct packed {
        fsm_e              fsm;
        logic              aw_pend;
        logic              w_pend;
        logic              ar_pend;
        txn_status_e       status;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [STRB_W-1:0] strb;
        logic [DATA_W-1:0] rdata;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [STRB_W-1:0] strb_new;
    logic              accept;
    logic              busy;
    logic              expired;
    txn_status_e       bcode;
    txn_status_e       rcode;

    axil_sm_strobe #(
        .STRB_W (STRB_W),
        .LANE_W (LANE_W)
    ) u_strobe (
        .size (cmd_size),
        .lane (cmd_addr[LANE_W-1:0]),
        .strb (strb_new)
    );

    axil_sm_timer #(
        .CNT_W (TMO_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .run     (busy),
        .limit   (tmo_limit),
        .expired (expired)
    );

    axil_sm_resp_map u_bmap (
        .resp (m_bresp),
        .code (bcode)
    );

    axil_sm_resp_map u_rmap (
        .resp (m_rresp),
        .code (rcode)
    );

    assign accept = cmd_valid && (ctx_q.fsm == FSM_IDLE);
    assign busy   = (ctx_q.fsm == FSM_WRITE) || (ctx_q.fsm == FSM_READ);

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.fsm)
            FSM_IDLE: begin
                if (cmd_valid) begin
                    ctx_d.fsm     = cmd_write ? FSM_WRITE : FSM_READ;
                    ctx_d.aw_pend = cmd_write;
                    ctx_d.w_pend  = cmd_write;
                    ctx_d.ar_pend = !cmd_write;
                    ctx_d.status  = TXN_BUSY;
                    ctx_d.addr    = cmd_addr;
                    ctx_d.wdata   = cmd_wdata;
                    ctx_d.strb    = strb_new;
                    ctx_d.rdata   = '0;
                end
            end
            FSM_WRITE: begin
                if (ctx_q.aw_pend && m_awready) ctx_d.aw_pend = 1'b0;
                if (ctx_q.w_pend && m_wready)   ctx_d.w_pend  = 1'b0;
                if (m_bvalid) begin
                    ctx_d.fsm     = FSM_REPLY;
                    ctx_d.status  = bcode;
                    ctx_d.aw_pend = 1'b0;
                    ctx_d.w_pend  = 1'b0;
                end else if (expired) begin
                    ctx_d.fsm     = FSM_REPLY;
                    ctx_d.status  = TXN_TIMEOUT;
                    ctx_d.aw_pend = 1'b0;
                    ctx_d.w_pend  = 1'b0;
                end
            end
            FSM_READ: begin
                if (ctx_q.ar_pend && m_arready) ctx_d.ar_pend = 1'b0;
                if (m_rvalid) begin
                    ctx_d.fsm     = FSM_REPLY;
                    ctx_d.status  = rcode;
                    ctx_d.rdata   = m_rdata;
                    ctx_d.ar_pend = 1'b0;
                end else if (expired) begin
                    ctx_d.fsm     = FSM_REPLY;
                    ctx_d.status  = TXN_TIMEOUT;
                    ctx_d.ar_pend = 1'b0;
                end
            end
            default: begin
                if (rsp_ready) ctx_d.fsm = FSM_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign cmd_ready  = (ctx_q.fsm == FSM_IDLE);
    assign rsp_valid  = (ctx_q.fsm == FSM_REPLY);
    assign rsp_status = ctx_q.status;
    assign rsp_rdata  = ctx_q.rdata;
    assign txn_state  = ctx_q.status;

    assign m_awvalid  = ctx_q.aw_pend;
    assign m_awaddr   = ctx_q.addr;
    assign m_wvalid   = ctx_q.w_pend;
    assign m_wdata    = ctx_q.wdata;
    assign m_wstrb    = ctx_q.strb;
    assign m_bready   = (ctx_q.fsm == FSM_WRITE);
    assign m_arvalid  = ctx_q.ar_pend;
    assign m_araddr   = ctx_q.addr;
    assign m_rready   = (ctx_q.fsm == FSM_READ);

endmodule

// File: rtl/axil_sm_checker.sv
module axil_sm_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int TMO_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TMO_W-1:0]  tmo_limit,
    input logic              cmd_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [2:0]        rsp_status,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [2:0]        txn_state,
    input logic              m_awvalid,
    input logic              m_awready,
    input logic [ADDR_W-1:0] m_awaddr,
    input logic              m_wvalid,
    input logic              m_wready,
    input logic              m_arvalid,
    input logic              m_arready
);

    logic [TMO_W:0] run_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt_q <= '0;
        end else if (txn_state == 3'd1) begin
            run_cnt_q <= run_cnt_q + 1'b1;
        end else begin
            run_cnt_q <= '0;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !(m_awvalid || m_wvalid || m_arvalid || rsp_valid)); // R1

    AST_BUSY_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid || m_wvalid || m_arvalid) |-> (txn_state == 3'd1 && !cmd_ready)); // R2

    AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> ((m_awvalid && $stable(m_awaddr)) || (rsp_valid && rsp_status == 3'd2))); // R3

    AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && !m_wready) |=> (m_wvalid || (rsp_valid && rsp_status == 3'd2))); // R3

    AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid && !m_arready) |=> (m_arvalid || (rsp_valid && rsp_status == 3'd2))); // R5

    AST_REPLY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status >= 3'd2 && rsp_status <= 3'd6)); // R6

    AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_state == 3'd1) |-> (run_cnt_q <= {1'b0, tmo_limit})); // R8

    AST_REPLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) && $stable(rsp_rdata))); // R9

    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_arvalid && (m_awvalid || m_wvalid))); // R10

endmodule

bind axil_single_master axil_sm_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .TMO_W  (TMO_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .tmo_limit  (tmo_limit),
    .cmd_ready  (cmd_ready),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_status (rsp_status),
    .rsp_rdata  (rsp_rdata),
    .txn_state  (txn_state),
    .m_awvalid  (m_awvalid),
    .m_awready  (m_awready),
    .m_awaddr   (m_awaddr),
    .m_wvalid   (m_wvalid),
    .m_wready   (m_wready),
    .m_arvalid  (m_arvalid),
    .m_arready  (m_arready)
);

// File: tb/test_axil_single_master.sv
module test_axil_single_master;

    localparam int AW = 32;
    localparam int DW = 64;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] tmo_limit = 8'd100;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic          cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic [2:0]    cmd_size = '0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b0;
    logic [2:0]    rsp_status;
    logic [DW-1:0] rsp_rdata;
    logic [2:0]    txn_state;
    logic          m_awvalid, m_wvalid, m_arvalid, m_bready, m_rready;
    logic          m_awready = 1'b0, m_wready = 1'b0, m_arready = 1'b0;
    logic          m_bvalid = 1'b0, m_rvalid = 1'b0;
    logic [1:0]    m_bresp = '0, m_rresp = '0;
    logic [DW-1:0] m_rdata = '0;
    logic [AW-1:0] m_awaddr, m_araddr;
    logic [DW-1:0] m_wdata;
    logic [7:0]    m_wstrb;

    always #5 clk = ~clk;

    axil_single_master #(.ADDR_W(AW), .DATA_W(DW), .TMO_W(TW)) i_axil_single_master (
        .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_size(cmd_size),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
        .rsp_rdata(rsp_rdata), .txn_state(txn_state),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
        .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp),
        .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
        .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata), .m_rresp(m_rresp)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Slave model knobs (written by the stimulus while the block is idle)
    int         aw_dly = 0, w_dly = 0, ar_dly = 0, rsp_dly = 0;
    bit         mute = 1'b0;
    logic [1:0] resp_code = 2'b00;
    logic [63:0] rd_pat = '0;

    // Slave model records
    int aw_age, w_age, ar_age, b_age, r_age;
    int aw_hs, w_hs, ar_hs, hs_cyc;
    bit aw_got, w_got, ar_got;
    logic [AW-1:0] cap_awaddr, cap_araddr;
    logic [DW-1:0] cap_wdata;
    logic [7:0]    cap_wstrb;

    always @(negedge clk) begin
        if (!rst_n || cmd_ready) begin
            aw_age = 0; w_age = 0; ar_age = 0; b_age = 0; r_age = 0;
            aw_hs = 0; w_hs = 0; ar_hs = 0;
            aw_got = 1'b0; w_got = 1'b0; ar_got = 1'b0;
            m_awready = 1'b0; m_wready = 1'b0; m_arready = 1'b0;
            m_bvalid = 1'b0; m_rvalid = 1'b0;
        end else begin
            // responses first, so they never precede an address handshake
            if (m_bvalid) begin
                m_bvalid = 1'b0;
            end else if (aw_got && w_got && !mute) begin
                if (b_age >= rsp_dly && m_bready) begin
                    m_bvalid = 1'b1; m_bresp = resp_code; hs_cyc = cyc + 1;
                    aw_got = 1'b0; w_got = 1'b0;
                end else begin
                    b_age++;
                end
            end
            if (m_rvalid) begin
                m_rvalid = 1'b0;
            end else if (ar_got && !mute) begin
                if (r_age >= rsp_dly && m_rready) begin
                    m_rvalid = 1'b1; m_rresp = resp_code; m_rdata = rd_pat; hs_cyc = cyc + 1;
                    ar_got = 1'b0;
                end else begin
                    r_age++;
                end
            end
            if (m_awvalid && aw_age >= aw_dly) begin
                m_awready = 1'b1; aw_hs++; cap_awaddr = m_awaddr; aw_got = 1'b1;
            end else begin
                m_awready = 1'b0; if (m_awvalid) aw_age++;
            end
            if (m_wvalid && w_age >= w_dly) begin
                m_wready = 1'b1; w_hs++; cap_wdata = m_wdata; cap_wstrb = m_wstrb; w_got = 1'b1;
            end else begin
                m_wready = 1'b0; if (m_wvalid) w_age++;
            end
            if (m_arvalid && ar_age >= ar_dly) begin
                m_arready = 1'b1; ar_hs++; cap_araddr = m_araddr; ar_got = 1'b1;
            end else begin
                m_arready = 1'b0; if (m_arvalid) ar_age++;
            end
        end
    end

    // Results of the last transfer
    int          acc_cyc, rsp_cyc;
    logic [2:0]  f_state, r_status, p_state;
    bit          f_ready, f_aw, f_w, f_ar, f_br, f_rr, bad_ready, early_rsp, held, p_ready, p_valid;
    bit          v_aw, v_w, v_ar;
    logic [63:0] r_data;

    task automatic run_txn(input bit wr, input logic [31:0] a, input logic [63:0] d,
                           input logic [2:0] s, input int hold, input int tmo_at);
        @(negedge clk);
        cmd_write = wr; cmd_addr = a; cmd_wdata = d; cmd_size = s; cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        acc_cyc = cyc + 1;
        @(negedge clk);
        cmd_valid = 1'b0;
        f_state = txn_state; f_ready = cmd_ready;
        f_aw = m_awvalid; f_w = m_wvalid; f_ar = m_arvalid; f_br = m_bready; f_rr = m_rready;
        bad_ready = 1'b0; early_rsp = 1'b0;
        while (!rsp_valid) begin
            if (cmd_ready) bad_ready = 1'b1;
            @(negedge clk);
        end
        rsp_cyc = cyc; r_status = rsp_status; r_data = rsp_rdata;
        v_aw = m_awvalid; v_w = m_wvalid; v_ar = m_arvalid;
        if (tmo_at >= 0 && rsp_cyc != tmo_at) early_rsp = 1'b1;
        held = 1'b1;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            if (!rsp_valid || rsp_status != r_status || rsp_rdata != r_data || cmd_ready) held = 1'b0;
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        p_ready = cmd_ready; p_valid = rsp_valid; p_state = txn_state;
    endtask

    function automatic logic [7:0] exp_strb(input int s, input int a);
        int bytes, base;
        if (s >= 3) return 8'hFF;
        bytes = 1 << s;
        base  = (a >> s) << s;
        return 8'(((1 << bytes) - 1) << base);
    endfunction

    initial begin : watchdog
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        chk(txn_state == 3'd0, "R1", "state", txn_state, 0);
        chk(cmd_ready == 1'b1, "R1", "cmd_ready", cmd_ready, 1);
        chk(!(m_awvalid || m_wvalid || m_arvalid || rsp_valid), "R1", "valids",
            {m_awvalid, m_wvalid, m_arvalid, rsp_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txn_state == 3'd0 && cmd_ready, "R1", "idle after release", txn_state, 0);

        // Write sweep: every size code against every lane offset
        for (int s = 0; s < 8; s++) begin
            for (int a = 0; a < 8; a++) begin
                logic [31:0] addr;
                logic [63:0] data;
                addr = 32'h4000_1000 + 32'(a) + 32'(s << 4);
                data = {32'hC0DE_0000 | 32'(s), 32'h0000_A500 | 32'(a)};
                aw_dly = a % 3; w_dly = (a + 1) % 3; rsp_dly = s % 3;
                resp_code = 2'((s + a) % 4); mute = 1'b0;
                run_txn(1'b1, addr, data, 3'(s), (a == 0) ? 2 : 0, -1);
                chk(f_state == 3'd1, "R2", "running state", f_state, 1);
                chk(!f_ready && !bad_ready, "R2", "ready low while busy", {f_ready, bad_ready}, 0);
                chk(f_aw && f_w && !f_ar, "R3", "valids together", {f_aw, f_w, f_ar}, 3'b110);
                chk(cap_awaddr == addr, "R3", "awaddr", cap_awaddr, addr);
                chk(cap_wdata == data, "R3", "wdata", cap_wdata, data);
                chk(cap_wstrb == exp_strb(s, a), "R4", "wstrb", cap_wstrb, exp_strb(s, a));
                chk(r_status == 3'(3 + int'(resp_code)), "R6", "write code", r_status, 3 + resp_code);
                chk(rsp_cyc == hs_cyc, "R6", "reply cycle", rsp_cyc, hs_cyc);
                chk(p_state == r_status, "R6", "state keeps result", p_state, r_status);
                chk(r_data == 64'd0, "R7", "write reply data", r_data, 0);
                chk(held, "R9", "reply held", held, 1);
                chk(p_ready && !p_valid, "R9", "ready again", {p_ready, p_valid}, 2'b10);
                chk(aw_hs == 1 && w_hs == 1 && ar_hs == 0, "R10", "write beats",
                    {aw_hs[7:0], w_hs[7:0], ar_hs[7:0]}, 24'h010100);
            end
        end

        // Read sweep: every response code against several latencies
        for (int c = 0; c < 4; c++) begin
            for (int dl = 0; dl < 3; dl++) begin
                logic [31:0] addr;
                addr = 32'h8000_0000 | 32'(c << 8) | 32'(dl << 3);
                ar_dly = dl; rsp_dly = 2 - dl; resp_code = 2'(c); mute = 1'b0;
                rd_pat = 64'h0123_4567_89AB_CDEF ^ 64'(c * 77 + dl);
                run_txn(1'b0, addr, 64'hDEAD, 3'd3, dl, -1);
                chk(f_ar && !f_aw && !f_w && f_rr, "R5", "read valid and ready",
                    {f_ar, f_aw, f_w, f_rr}, 4'b1001);
                chk(cap_araddr == addr, "R5", "araddr", cap_araddr, addr);
                chk(r_status == 3'(3 + c), "R6", "read code", r_status, 3 + c);
                chk(rsp_cyc == hs_cyc, "R6", "read reply cycle", rsp_cyc, hs_cyc);
                chk(r_data == rd_pat, "R7", "read data", r_data, rd_pat);
                chk(held && p_ready, "R9", "read reply hold", {held, p_ready}, 2'b11);
                chk(ar_hs == 1 && aw_hs == 0 && w_hs == 0, "R10", "read beats",
                    {ar_hs[7:0], aw_hs[7:0], w_hs[7:0]}, 24'h010000);
            end
        end

        // Timeouts at several limits, for writes and reads
        for (int t = 0; t < 4; t++) begin
            for (int wr = 0; wr < 2; wr++) begin
                int lim;
                lim = (t == 3) ? 7 : t;
                tmo_limit = 8'(lim); mute = 1'b1;
                aw_dly = (t[0]) ? 1000 : 0; w_dly = 1000; ar_dly = (t[0]) ? 1000 : 0;
                run_txn(wr[0], 32'h0000_0F00, 64'h5A5A, 3'd2, 1, -1);
                chk(rsp_cyc == acc_cyc + lim + 1, "R8", "timeout cycle", rsp_cyc, acc_cyc + lim + 1);
                chk(r_status == 3'd2, "R8", "timeout code", r_status, 2);
                chk(!v_aw && !v_w && !v_ar, "R8", "valids dropped", {v_aw, v_w, v_ar}, 0);
                chk(r_data == 64'd0, "R7", "timeout data", r_data, 0);
                chk(p_state == 3'd2 && p_ready, "R9", "idle after timeout", p_state, 2);
            end
        end

        // A response inside the limit is not a timeout
        tmo_limit = 8'd6; mute = 1'b0; aw_dly = 0; w_dly = 0; rsp_dly = 2; resp_code = 2'b00;
        run_txn(1'b1, 32'h10, 64'h1, 3'd0, 0, -1);
        chk(r_status == 3'd3, "R8", "answered before limit", r_status, 3);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule